// File: doc/BRIEF.md
# Zone Write-Permission Filter

The filter sits between a write command decoder and a non-volatile byte array. For each byte the decoder wants to write, it looks at the protection mode of the addressed zone and decides two things: whether the array may be written, and what value is placed in it. The decoder supplies the mode, the byte's position within its 8-byte page, the new byte, the byte now stored, the lock byte of the page and the byte's index within the current burst.

Four modes are handled. Unrestricted zones take bursts of up to 16 bytes as sent. Program-only zones can only clear bits. Modify-forbidden zones reject every write. Write-lock zones treat the first byte of every 8-byte page as a mask in which bit n, when 0, freezes byte n of that page. That first byte can itself only lose bits, and a cleared bit 0 freezes it entirely. A write-lock burst is cut to its first byte. Zone selection, passwords, authentication, page buffering and array timing are handled elsewhere.

The decision is registered. A request presented in one cycle produces its write enable, deny flag and data in the next cycle.

Top module: `wp_filter`

## Requirements
- R1: After reset, wrEn, deny and wrData are all 0.
- R2: Each result appears one clock after the request (reqValid high). In a cycle with no request, wrEn and deny are both 0 in the following cycle.
- R3: Mode code 0 (unrestricted) grants every request at any burst index 0..15 and stores newData unchanged.
- R4: Mode code 1 (program-only) grants every request and stores oldData AND newData, so no bit goes from 0 to 1.
- R5: Mode code 2 (modify-forbidden) denies every request.
- R6: Mode code 3 (write-lock) denies every request whose burstIdx is not 0.
- R7: In mode 3 with burstIdx 0 and pageOffset n in 1..7, the write is granted and stores newData when bit n of lockByte is 1. It is denied when that bit is 0.
- R8: In mode 3 with burstIdx 0 and pageOffset 0 (the lock byte itself), the write is denied when bit 0 of lockByte is 0. Otherwise it is granted and stores oldData AND newData.
- R9: For every request exactly one of wrEn and deny is 1. Whenever wrEn is 0, wrData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A byte write request is present |
| zoneMode | input | 2 | Protection mode: 0 free, 1 program-only, 2 forbidden, 3 write-lock |
| pageOffset | input | 3 | Low address bits: byte position in its 8-byte page |
| burstIdx | input | 4 | Index of this byte within the write burst |
| newData | input | 8 | Byte the host wants to write |
| oldData | input | 8 | Byte currently stored at the address |
| lockByte | input | 8 | Current lock byte of the addressed page |
| wrEn | output | 1 | Array write enable for this byte |
| deny | output | 1 | The request was rejected |
| wrData | output | 8 | Value to store when wrEn is 1 |

## Verification
Two rules can apply to one write-lock request in the same cycle. The burst cut can coincide with the page mask: a request with a non-zero burst index can target a byte whose mask bit is 1. The self-lock of the lock byte can coincide with the clear-only merge: a request can try to set bits of the lock byte while its bit 0 is already 0. The bench builds both situations directly and also draws random mask, offset and index combinations. The burst cut must win over an open mask bit, and a self-locked lock byte must be denied with no merged data on wrData.

// File: rtl/wp_filter_pkg.sv
package wp_filter_pkg;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_FORBID = 2'd2,
    MODE_LOCK   = 2'd3
  } zoneMode_e;

  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic grant;    // write may go to the array
    logic refuse;   // request rejected
    logic clearOnly;// store old AND new instead of new
  } wpStrobe_t;

endpackage

// File: rtl/wp_filter_ctrl.sv
module wp_filter_ctrl
  import wp_filter_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int IDX_W      = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  reqValid,
  input  logic [1:0]            zoneMode,
  input  logic [OFF_W-1:0]      pageOffset,
  input  logic [IDX_W-1:0]      burstIdx,
  input  logic [PAGE_BYTES-1:0] lockByte,
  output wpStrobe_t             strobe
);

  logic isLockByte;
  logic maskOpen;
  logic firstOfBurst;

  assign isLockByte   = (pageOffset == '0);
  assign maskOpen     = lockByte[pageOffset];
  assign firstOfBurst = (burstIdx == '0);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      unique case (zoneMode_e'(zoneMode))
        MODE_FREE: strobe.grant = 1'b1;
        MODE_PROG: begin
          strobe.grant     = 1'b1;
          strobe.clearOnly = 1'b1;
        end
        MODE_FORBID: strobe.refuse = 1'b1;
        MODE_LOCK: begin
          if (firstOfBurst && maskOpen) begin
            strobe.grant     = 1'b1;
            strobe.clearOnly = isLockByte;
          end else begin
            strobe.refuse = 1'b1;
          end
        end
        default: strobe.refuse = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/wp_filter_dp.sv
module wp_filter_dp
  import wp_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         strobe,
  input  logic [DATA_W-1:0] newData,
  input  logic [DATA_W-1:0] oldData,
  output logic              wrEn,
  output logic              deny,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] merged;

  assign merged = strobe.clearOnly ? (oldData & newData) : newData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      deny   <= 1'b0;
      wrData <= '0;
    end else begin
      wrEn   <= strobe.grant;
      deny   <= strobe.refuse;
      wrData <= strobe.grant ? merged : '0;
    end
  end

endmodule

// File: rtl/wp_filter.sv
module wp_filter
  import wp_filter_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int IDX_W      = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            zoneMode,
  input  logic [OFF_W-1:0]      pageOffset,
  input  logic [IDX_W-1:0]      burstIdx,
  input  logic [DATA_W-1:0]     newData,
  input  logic [DATA_W-1:0]     oldData,
  input  logic [PAGE_BYTES-1:0] lockByte,
  output logic                  wrEn,
  output logic                  deny,
  output logic [DATA_W-1:0]     wrData
);

  wpStrobe_t strobe;

  wp_filter_ctrl #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .reqValid  (reqValid),
    .zoneMode  (zoneMode),
    .pageOffset(pageOffset),
    .burstIdx  (burstIdx),
    .lockByte  (lockByte),
    .strobe    (strobe)
  );

  wp_filter_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .newData(newData),
    .oldData(oldData),
    .wrEn   (wrEn),
    .deny   (deny),
    .wrData (wrData)
  );

endmodule

// File: rtl/wp_filter_chk.sv
module wp_filter_chk #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int IDX_W      = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [1:0]            zoneMode,
  input logic [OFF_W-1:0]      pageOffset,
  input logic [IDX_W-1:0]      burstIdx,
  input logic [DATA_W-1:0]     newData,
  input logic [DATA_W-1:0]     oldData,
  input logic [PAGE_BYTES-1:0] lockByte,
  input logic                  wrEn,
  input logic                  deny,
  input logic [DATA_W-1:0]     wrData
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!wrEn && !deny));

  // R3
  free_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && zoneMode == 2'd0) |=> (wrEn && wrData == $past(newData)));

  // R4
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && zoneMode == 2'd1) |=> (wrEn && (wrData & ~$past(oldData)) == '0));

  // R5
  forbid_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && zoneMode == 2'd2) |=> (deny && !wrEn));

  // R6
  burst_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && zoneMode == 2'd3 && burstIdx != '0) |=> (deny && !wrEn));

  // R8
  self_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && zoneMode == 2'd3 && pageOffset == '0 && !lockByte[0]) |=> deny);

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> $onehot({wrEn, deny}));

  // R9
  data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (wrData == '0));

endmodule

bind wp_filter wp_filter_chk #(
  .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)
) u_wp_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .zoneMode(zoneMode),
  .pageOffset(pageOffset), .burstIdx(burstIdx), .newData(newData),
  .oldData(oldData), .lockByte(lockByte), .wrEn(wrEn), .deny(deny),
  .wrData(wrData)
);

// File: tb/test_wp_filter.sv
`timescale 1ns/1ps
module test_wp_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] zoneMode = '0;
  logic [2:0] pageOffset = '0;
  logic [3:0] burstIdx = '0;
  logic [7:0] newData = '0;
  logic [7:0] oldData = '0;
  logic [7:0] lockByte = '0;
  logic       wrEn;
  logic       deny;
  logic [7:0] wrData;

  int checks = 0;
  int failures = 0;
  logic [9:0] pending;
  string pendTag;

  always #2 clk = ~clk;

  wp_filter i_wp_filter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .zoneMode(zoneMode),
    .pageOffset(pageOffset), .burstIdx(burstIdx), .newData(newData),
    .oldData(oldData), .lockByte(lockByte), .wrEn(wrEn), .deny(deny),
    .wrData(wrData)
  );

  // Expected {wrEn, deny, wrData}
  function automatic logic [9:0] model(input logic v, input logic [1:0] m,
      input logic [2:0] off, input logic [3:0] idx, input logic [7:0] nd,
      input logic [7:0] od, input logic [7:0] lk);
    if (!v) return 10'b0;
    case (m)
      2'd0: return {2'b10, nd};
      2'd1: return {2'b10, od & nd};
      2'd2: return {2'b01, 8'h00};
      default: begin
        if (idx != 0 || !lk[off]) return {2'b01, 8'h00};
        if (off == 0) return {2'b10, od & nd};
        return {2'b10, nd};
      end
    endcase
  endfunction

  function automatic string tagOf(input logic v, input logic [1:0] m,
      input logic [2:0] off, input logic [3:0] idx);
    if (!v) return "R2";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: begin
        if (idx != 0) return "R6";
        if (off == 0) return "R8";
        return "R7";
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    checks++;
    if ({wrEn, deny, wrData} !== exp) begin
      failures++;
      $display("FAIL %s actual=%b/%b/%h expected=%b/%b/%h", tag,
               wrEn, deny, wrData, exp[9], exp[8], exp[7:0]);
    end
    if (reqValid === 1'b0 && 0) $display("");
  endtask

  // Present one request at a negedge, check it at the next negedge
  task automatic req(input logic v, input logic [1:0] m, input logic [2:0] off,
      input logic [3:0] idx, input logic [7:0] nd, input logic [7:0] od,
      input logic [7:0] lk);
    reqValid = v; zoneMode = m; pageOffset = off; burstIdx = idx;
    newData = nd; oldData = od; lockByte = lk;
    @(negedge clk);
    check(tagOf(v, m, off, idx), model(v, m, off, idx, nd, od, lk));
    if (!v) begin
      // R9: no write means zero data
      checks++;
      if (wrData !== 8'h00) begin
        failures++;
        $display("FAIL R9 actual=%h expected=00", wrData);
      end
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd5821;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 10'b0);
    rstN = 1'b1;
    @(negedge clk);
    req(1'b0, 2'd0, 3'd0, 4'd0, 8'hFF, 8'h00, 8'hFF);        // R2 idle
    req(1'b1, 2'd0, 3'd5, 4'd15, 8'hA5, 8'h3C, 8'h00);       // R3 last burst byte
    req(1'b1, 2'd0, 3'd0, 4'd0, 8'h00, 8'hFF, 8'h00);        // R3
    req(1'b1, 2'd1, 3'd2, 4'd7, 8'hFF, 8'h0F, 8'hFF);        // R4 set attempt
    req(1'b1, 2'd1, 3'd2, 4'd0, 8'h55, 8'hF0, 8'hFF);        // R4
    req(1'b1, 2'd2, 3'd1, 4'd0, 8'h12, 8'h34, 8'hFF);        // R5
    req(1'b1, 2'd3, 3'd3, 4'd1, 8'h77, 8'h00, 8'hFF);        // R6 mask open, cut
    req(1'b1, 2'd3, 3'd3, 4'd0, 8'h77, 8'h00, 8'hF7);        // R7 locked
    req(1'b1, 2'd3, 3'd3, 4'd0, 8'h77, 8'h00, 8'h08);        // R7 open
    req(1'b1, 2'd3, 3'd7, 4'd0, 8'h9A, 8'h00, 8'h80);        // R7 top bit
    req(1'b1, 2'd3, 3'd0, 4'd0, 8'hFF, 8'hFE, 8'hFE);        // R8 self-locked
    req(1'b1, 2'd3, 3'd0, 4'd0, 8'hFF, 8'hD9, 8'hD9);        // R8 set attempt
    req(1'b1, 2'd3, 3'd0, 4'd0, 8'h0F, 8'hD9, 8'hD9);        // R8 clear
    req(1'b1, 2'd3, 3'd0, 4'd2, 8'h0F, 8'hD9, 8'hD9);        // R6 on lock byte
    req(1'b0, 2'd3, 3'd0, 4'd0, 8'h0F, 8'hD9, 8'hD9);        // R2 idle again
    for (int i = 0; i < 400; i++) begin
      logic [7:0] od, lk;
      logic [2:0] off;
      od  = 8'($urandom);
      off = 3'($urandom);
      lk  = (off == 0) ? od : 8'($urandom);
      req(($urandom % 8) != 0, 2'($urandom), off,
          ($urandom % 2) ? 4'd0 : 4'($urandom), 8'($urandom), od, lk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule